// File: doc/BRIEF.md
# Helicity-Window Scaler Bank

This block counts how often each trigger condition fires during one helicity window, and it also counts ticks of a slow reference clock over the same window. A helicity window runs from one rising edge of the external window-start strobe to the next. The strobe is asynchronous to the block clock, so it passes through a synchronizer before its rising edge is detected. The rising edge is the latch moment.

At each latch moment, every live counter is copied into a snapshot bank and then restarts for the new window. The current helicity and quartet levels are captured beside the counts. A readout request is raised, and it stays high until the readout side acknowledges it. If a new window closes while a request is still pending, the snapshot is overwritten with the newest window and a lost-window flag is raised.

Each counter saturates instead of wrapping. Each counter also carries a sticky overflow bit that covers one window.

Top module: `hws_bank`

## Requirements
- R1: While reset is held, and until the first latch after reset, all snapshot counts, snapshot overflow bits, the captured helicity and quartet bits, the request and the lost-window flag read zero.
- R2: A rising edge on `win_start` latches the bank on the third rising clock edge after the input goes high (two synchronizer flops plus one edge-detect flop). A falling edge, or a level that is held high, latches nothing and leaves the snapshot unchanged.
- R3: Snapshot slot i, for i below NUM_COND, holds the number of clock cycles in the closed window in which `cond_pulse[i]` was sampled high.
- R4: The last snapshot slot, index NUM_COND, holds the number of cycles in the closed window in which `ref_tick` was sampled high.
- R5: A pulse sampled on the latch edge itself belongs to the new window, so the new window starts its count at 1.
- R6: A count stops at 2^CNT_W-1. The slot's `snap_ovf` bit is 1 if an increment was attempted at that value during the closed window. Each window starts with the overflow bit clear.
- R7: `snap_hel` and `snap_quartet` hold the values of `hel_in` and `quartet_in` as sampled on the latch edge.
- R8: `rd_req` rises on the latch edge. It stays high until a cycle in which `rd_ack` is high and no latch occurs.
- R9: A latch taken while `rd_req` is high and `rd_ack` is low sets `lost_win`. An acknowledge cycle clears `lost_win`. A latch that falls in the same cycle as an acknowledge keeps `rd_req` high and does not set `lost_win`.
- R10: Slot i of the snapshot occupies bits [i*CNT_W +: CNT_W] of `snap_counts`, and its overflow bit is `snap_ovf[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_pulse | input | NUM_COND | One-cycle condition pulses from the trigger former |
| ref_tick | input | 1 | One-cycle tick of the reference clock |
| win_start | input | 1 | Asynchronous window-start strobe |
| hel_in | input | 1 | Helicity level |
| quartet_in | input | 1 | Quartet-start level |
| rd_ack | input | 1 | Readout acknowledge |
| rd_req | output | 1 | Snapshot ready for readout |
| lost_win | output | 1 | A window was overwritten before acknowledge |
| snap_counts | output | (NUM_COND+1)*CNT_W | Packed snapshot counts |
| snap_ovf | output | NUM_COND+1 | Snapshot overflow bits |
| snap_hel | output | 1 | Captured helicity |
| snap_quartet | output | 1 | Captured quartet flag |

## Verification
The condition inputs are driven with a binary-counting pulse pattern, with the reference tick firing on every third cycle. This separates the channels from one another and shows whether any slot is misplaced in the packed bus. A long window with one channel and the tick held high drives both counts into saturation. The short window after it shows that the overflow bit clears.

A pulse placed exactly on the latch edge shows which window claims it. A strobe that stays high, and then falls, shows that only the rising edge latches. Windows that close with no acknowledge, and with the acknowledge landing in the same cycle as the latch, tell the lost-window rule apart from the plain pending-request rule.

// File: rtl/hws_pkg.sv
package hws_pkg;

  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_PEND = 1'b1
  } rd_state_e;

endpackage

// File: rtl/hws_sync_edge.sv
module hws_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
    prev_d = sync_q[STAGES-1];
    rise_o = sync_q[STAGES-1] & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/hws_chan.sv
module hws_chan #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             latch_i,
  output logic [CNT_W-1:0] snap_cnt_o,
  output logic             snap_ovf_o
);

  logic [CNT_W-1:0] live_q, live_d;
  logic             ovf_q, ovf_d;
  logic [CNT_W-1:0] snap_q;
  logic             sovf_q;
  logic             live_en;
  logic             at_max;

  always_comb begin
    at_max  = &live_q;
    live_d  = live_q;
    ovf_d   = ovf_q;
    live_en = latch_i | inc_i;
    if (latch_i) begin
      live_d = {{(CNT_W-1){1'b0}}, inc_i};
      ovf_d  = 1'b0;
    end else if (inc_i) begin
      if (at_max) begin
        ovf_d = 1'b1;
      end else begin
        live_d = live_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      ovf_q  <= 1'b0;
    end else if (live_en) begin
      live_q <= live_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      sovf_q <= 1'b0;
    end else if (latch_i) begin
      snap_q <= live_q;
      sovf_q <= ovf_q;
    end
  end

  assign snap_cnt_o = snap_q;
  assign snap_ovf_o = sovf_q;

endmodule

// File: rtl/hws_readout.sv
module hws_readout
  import hws_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic latch_i,
  input  logic ack_i,
  output logic req_o,
  output logic lost_o
);

  rd_state_e state_q, state_d;
  logic      lost_q, lost_d;

  always_comb begin
    state_d = state_q;
    lost_d  = lost_q;
    unique case (state_q)
      RD_IDLE: begin
        if (latch_i) state_d = RD_PEND;
      end
      RD_PEND: begin
        if (latch_i) begin
          lost_d = ~ack_i;
        end else if (ack_i) begin
          state_d = RD_IDLE;
          lost_d  = 1'b0;
        end
      end
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      lost_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lost_q  <= lost_d;
    end
  end

  assign req_o  = (state_q == RD_PEND);
  assign lost_o = lost_q;

endmodule

// File: rtl/hws_bank.sv
module hws_bank
  import hws_pkg::*;
#(
  parameter int unsigned NUM_COND    = 4,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_COND-1:0]             cond_pulse,
  input  logic                            ref_tick,
  input  logic                            win_start,
  input  logic                            hel_in,
  input  logic                            quartet_in,
  input  logic                            rd_ack,
  output logic                            rd_req,
  output logic                            lost_win,
  output logic [(NUM_COND+1)*CNT_W-1:0]   snap_counts,
  output logic [NUM_COND:0]               snap_ovf,
  output logic                            snap_hel,
  output logic                            snap_quartet
);

  localparam int unsigned NUM_CH = NUM_COND + 1;

  logic              win_latch;
  logic [NUM_CH-1:0] inc_vec;
  logic              hel_q, hel_d;
  logic              qrt_q, qrt_d;

  assign inc_vec = {ref_tick, cond_pulse};

  hws_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(win_start),
    .rise_o (win_latch)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    hws_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_i     (inc_vec[ch]),
      .latch_i   (win_latch),
      .snap_cnt_o(snap_counts[ch*CNT_W +: CNT_W]),
      .snap_ovf_o(snap_ovf[ch])
    );
  end

  always_comb begin
    hel_d = hel_in;
    qrt_d = quartet_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hel_q <= 1'b0;
      qrt_q <= 1'b0;
    end else if (win_latch) begin
      hel_q <= hel_d;
      qrt_q <= qrt_d;
    end
  end

  assign snap_hel     = hel_q;
  assign snap_quartet = qrt_q;

  hws_readout u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .latch_i(win_latch),
    .ack_i  (rd_ack),
    .req_o  (rd_req),
    .lost_o (lost_win)
  );

endmodule

// File: rtl/hws_bank_chk.sv
module hws_bank_chk #(
  parameter int unsigned SNAP_W = 160
) (
  input logic              clk,
  input logic              rst_n,
  input logic              latch_i,
  input logic              rd_req,
  input logic              rd_ack,
  input logic              lost_win,
  input logic              hel_in,
  input logic              snap_hel,
  input logic [SNAP_W-1:0] snap_counts
);

  // R2
  snap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_i |=> $stable(snap_counts));

  // R8
  req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_i |=> rd_req);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack && !latch_i |=> rd_req);

  // R9
  lost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_i && rd_req && !rd_ack |=> lost_win);

  // R9
  lost_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && !latch_i |=> !lost_win);

  // R7
  hel_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_i |=> snap_hel == $past(hel_in));

endmodule

bind hws_bank hws_bank_chk #(.SNAP_W(NUM_CH*CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .latch_i    (win_latch),
  .rd_req     (rd_req),
  .rd_ack     (rd_ack),
  .lost_win   (lost_win),
  .hel_in     (hel_in),
  .snap_hel   (snap_hel),
  .snap_counts(snap_counts)
);

// File: tb/hws_bank_bench.sv
module hws_bank_bench;
  localparam int NC   = 4;
  localparam int CW   = 4;
  localparam int NCH  = NC + 1;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [NC-1:0]     cond;
  logic              tick, mps, hel, qt, rd_ack;
  logic              rd_req, lost_win, snap_hel, snap_qt;
  logic [NCH*CW-1:0] snap_counts;
  logic [NCH-1:0]    snap_ovf;

  hws_bank #(.NUM_COND(NC), .CNT_W(CW), .SYNC_STAGES(2)) u_hws_bank (
    .clk(clk), .rst_n(rst_n), .cond_pulse(cond), .ref_tick(tick),
    .win_start(mps), .hel_in(hel), .quartet_in(qt), .rd_ack(rd_ack),
    .rd_req(rd_req), .lost_win(lost_win), .snap_counts(snap_counts),
    .snap_ovf(snap_ovf), .snap_hel(snap_hel), .snap_quartet(snap_qt)
  );

  typedef struct packed {
    logic [NCH*CW-1:0] cnt;
    logic [NCH-1:0]    ovf;
    logic              hel;
    logic              qt;
  } snap_t;

  snap_t exp_q[$];
  int    errors = 0;
  int    checks = 0;
  bit    check_due = 0;
  bit    done = 0;
  int    exp_live[NCH];
  bit    exp_ovf[NCH];
  logic [3:0] mh;
  logic [NCH*CW-1:0] held_cnt;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // driver: one clock edge per call, bench model of the window counts
  task automatic step(input logic [NC-1:0] c, input logic t, input logic m, input logic a);
    logic [NCH-1:0] incv;
    snap_t s;
    @(negedge clk);
    cond = c; tick = t; mps = m; rd_ack = a;
    mh   = {mh[2:0], m};
    incv = {t, c};
    if (mh[2] && !mh[3]) begin
      for (int ch = 0; ch < NCH; ch++) begin
        s.cnt[ch*CW +: CW] = exp_live[ch][CW-1:0];
        s.ovf[ch]          = exp_ovf[ch];
      end
      s.hel = hel;
      s.qt  = qt;
      exp_q.push_back(s);
      check_due = 1;
      for (int ch = 0; ch < NCH; ch++) begin
        exp_live[ch] = incv[ch] ? 1 : 0;  // R5 pulse on latch edge opens new window
        exp_ovf[ch]  = 0;
      end
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (incv[ch]) begin
          if (exp_live[ch] == MAXV) exp_ovf[ch] = 1;
          else exp_live[ch]++;
        end
      end
    end
  endtask

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic open_close(input logic [NC-1:0] c_on_latch, input logic ack_on_latch);
    step('0, 1'b0, 1'b1, 1'b0);
    step('0, 1'b0, 1'b1, 1'b0);
    step(c_on_latch, 1'b0, 1'b1, ack_on_latch);
    step('0, 1'b0, 1'b0, 1'b0);
  endtask

  // monitor: pops expected snapshot after each latch edge
  initial begin
    snap_t e;
    forever begin
      @(posedge clk);
      #5;
      if (check_due) begin
        check_due = 0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 queue", 64'd0, 64'd1);
        end else begin
          e = exp_q.pop_front();
          // R3 R10 condition slots
          chk(snap_counts[NC*CW-1:0] == e.cnt[NC*CW-1:0], "R3 R10 counts",
              64'(snap_counts[NC*CW-1:0]), 64'(e.cnt[NC*CW-1:0]));
          // R4 reference slot
          chk(snap_counts[NC*CW +: CW] == e.cnt[NC*CW +: CW], "R4 ref count",
              64'(snap_counts[NC*CW +: CW]), 64'(e.cnt[NC*CW +: CW]));
          chk(snap_ovf == e.ovf, "R6 overflow", 64'(snap_ovf), 64'(e.ovf));
          chk({snap_hel, snap_qt} == {e.hel, e.qt}, "R7 hel/quartet",
              64'({snap_hel, snap_qt}), 64'({e.hel, e.qt}));
          chk(rd_req == 1'b1, "R8 request raised", 64'(rd_req), 64'd1);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cond = '0; tick = 0; mps = 0; hel = 0; qt = 0; rd_ack = 0;
    mh = '0;
    for (int ch = 0; ch < NCH; ch++) begin exp_live[ch] = 0; exp_ovf[ch] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(snap_counts == '0 && snap_ovf == '0, "R1 snapshot zero", 64'(snap_counts), 64'd0);
    chk({rd_req, lost_win, snap_hel, snap_qt} == 4'b0, "R1 flags zero",
        64'({rd_req, lost_win, snap_hel, snap_qt}), 64'd0);
    rst_n = 1'b1;

    // window A: counting pattern, ref tick every third cycle (R3 R4 R10)
    hel = 1; qt = 0;
    for (int i = 0; i < 10; i++) step(NC'(i), (i % 3) == 0, 1'b0, 1'b0);
    open_close('0, 1'b0);
    idle(1);
    step('0, 1'b0, 1'b0, 1'b1);
    settle();
    chk(rd_req == 1'b0, "R8 ack clears", 64'(rd_req), 64'd0);
    held_cnt = snap_counts;
    // R2: strobe already fell, hold low; nothing latches
    idle(8);
    settle();
    chk(snap_counts == held_cnt, "R2 no latch on fall/idle", 64'(snap_counts), 64'(held_cnt));
    chk(rd_req == 1'b0, "R2 no request", 64'(rd_req), 64'd0);

    // window B: pulse on the latch edge (R5), strobe held high longer (R2)
    hel = 0; qt = 1;
    for (int i = 0; i < 6; i++) step(4'b0101, 1'b1, 1'b0, 1'b0);
    open_close(4'b1111, 1'b0);
    for (int i = 0; i < 4; i++) step(4'b1000, 1'b0, 1'b1, 1'b0);
    step('0, 1'b0, 1'b0, 1'b1);
    idle(3);

    // window C: saturation (R6)
    hel = 1; qt = 1;
    for (int i = 0; i < 20; i++) step(4'b0010, 1'b1, 1'b0, 1'b0);
    open_close('0, 1'b0);
    step('0, 1'b0, 1'b0, 1'b1);
    idle(3);

    // window D: short, overflow cleared (R6), left unacknowledged
    hel = 0; qt = 0;
    for (int i = 0; i < 5; i++) step(4'b0010, 1'b0, 1'b0, 1'b0);
    open_close('0, 1'b0);
    idle(2);
    settle();
    chk(lost_win == 1'b0, "R9 no loss yet", 64'(lost_win), 64'd0);

    // window E: closes while request pending (R9)
    for (int i = 0; i < 3; i++) step(4'b0001, 1'b0, 1'b0, 1'b0);
    open_close('0, 1'b0);
    settle();
    chk(lost_win == 1'b1, "R9 lost set", 64'(lost_win), 64'd1);
    chk(rd_req == 1'b1, "R8 still pending", 64'(rd_req), 64'd1);
    step('0, 1'b0, 1'b0, 1'b1);
    settle();
    chk({rd_req, lost_win} == 2'b00, "R9 ack clears lost", 64'({rd_req, lost_win}), 64'd0);

    // windows F/G: acknowledge coinciding with latch (R9)
    idle(2);
    open_close('0, 1'b0);
    step(4'b0100, 1'b0, 1'b0, 1'b0);
    open_close('0, 1'b1);
    settle();
    chk(rd_req == 1'b1, "R9 req kept on ack+latch", 64'(rd_req), 64'd1);
    chk(lost_win == 1'b0, "R9 no loss on ack+latch", 64'(lost_win), 64'd0);
    step('0, 1'b0, 1'b0, 1'b1);
    settle();
    chk(rd_req == 1'b0, "R8 final ack", 64'(rd_req), 64'd0);
    idle(2);
    chk(exp_q.size() == 0, "R2 all windows seen", 64'(exp_q.size()), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule